// File: doc/BRIEF.md
# SPI Chip-Select Expander

This block lets a host that has only two spare select pins reach many SPI peripherals on a shared bus. The host supplies the serial clock, its data-out line and two active-low selects. One of them is the configuration select. While it is low, the expander itself is the SPI target: it takes in a target-address byte and stores it when that select returns high. The other is the device select. While it is low, the expander pulls low exactly one of its output chip-selects, the one given by the stored address. The serial clock and data are copied unchanged to the peripherals.

The select inputs and the sampled copy of the serial clock are brought into the system clock domain through two-flop synchronizers. The system clock must run at least four times faster than the serial clock. A small state machine receives the address frame. It has four states. `ST_IDLE` waits for the configuration select. `ST_SHIFT` takes in bits until the eighth one arrives. `ST_FULL` holds a complete byte. `ST_OVER` marks a frame that has too many bits. The transitions are as follows. `ST_IDLE` goes to `ST_SHIFT` when the configuration select becomes active. `ST_SHIFT` goes to `ST_FULL` on the eighth rising clock edge. `ST_FULL` goes to `ST_OVER` on any further rising edge. Every state except `ST_IDLE` goes back to `ST_IDLE` when the select goes inactive. Only the exit from `ST_FULL` commits the byte.

Top module: `spi_select_expander`

## Requirements
- R1: `sclk_o` and `mosi_o` are combinational copies of `sclk_i` and `mosi_i` at all times.
- R2: While `cfg_sel_n` is low, `mosi_i` is sampled on each rising edge of `sclk_i`, most significant bit first. If exactly 8 bits arrived, the byte becomes the stored address once `cfg_sel_n` rises.
- R3: A configuration frame that carries fewer or more than 8 bits leaves both the stored address and `addr_err_o` unchanged.
- R4: Take a stored address A below `NUM_OUTS`. While `dev_sel_n` is low and `cfg_sel_n` is high, only `cs_n_o[A]` is low and every other output chip-select is high.
- R5: Every bit of `cs_n_o` is high while `dev_sel_n` is high, and while `rst_n` is low.
- R6: While `cfg_sel_n` is low, every bit of `cs_n_o` is high, even if `dev_sel_n` is also low.
- R7: A committed byte at or above `NUM_OUTS` sets `addr_err_o` to 1, and no output asserts when the device select is used. The flag stays at 1 until a committed byte below `NUM_OUTS` clears it.
- R8: After reset the stored address is 0 and `addr_err_o` is 0.
- R9: `cs_n_o` takes the new value at the third rising edge of `clk` after a change of `dev_sel_n`: two synchronizer stages, then the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host (mode 0, idles low) |
| mosi_i | input | 1 | Serial data from the host |
| cfg_sel_n | input | 1 | Active-low select addressing the expander itself |
| dev_sel_n | input | 1 | Active-low select steered to one peripheral |
| sclk_o | output | 1 | Serial clock to the peripherals |
| mosi_o | output | 1 | Serial data to the peripherals |
| cs_n_o | output | NUM_OUTS | Active-low peripheral chip-selects |
| addr_err_o | output | 1 | Sticky out-of-range address flag |

## Verification
The bench builds the block with `NUM_OUTS` = 12, which is not a power of two. Addresses 12 to 15 fit the decoder's natural width but are still out of range, and many random bytes fall beyond the output count, so the error flag is set and cleared many times. Frame lengths of 5, 7, 8 and 9 bits are mixed, so every path into and out of `ST_FULL` and `ST_OVER` is taken. Directed cases cover reset, the case where both selects are low at once, and the exact three-edge latency of the output chip-selects.

// File: rtl/spi_exp_pkg.sv
package spi_exp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FULL  = 2'd2,
        ST_OVER  = 2'd3
    } cfg_state_t;
endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                stab_q <= RST_VAL[i];
            end else begin
                meta_q <= d_i[i];
                stab_q <= meta_q;
            end
        end
        assign q_o[i] = stab_q;
    end
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter
    import spi_exp_pkg::*;
#(
    parameter int NUM_OUTS   = 16,
    parameter int FRAME_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_act,
    input  logic                  sclk_s,
    input  logic                  mosi_s,
    output logic [FRAME_BITS-1:0] addr_o,
    output logic                  err_o
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [FRAME_BITS:0]  LIMIT    = (FRAME_BITS+1)'(NUM_OUTS);
    localparam logic [CNT_W-1:0]     LAST_BIT = CNT_W'(FRAME_BITS - 1);

    cfg_state_t            state_q, state_d;
    logic                  sclk_d;
    logic                  sclk_rise;
    logic [FRAME_BITS-1:0] shift_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [FRAME_BITS-1:0] addr_q;
    logic                  err_q;
    logic                  commit;
    logic                  take_bit;

    assign sclk_rise = sclk_s & ~sclk_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cfg_act) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (!cfg_act)                             state_d = ST_IDLE;
                else if (sclk_rise && cnt_q == LAST_BIT)  state_d = ST_FULL;
            end
            ST_FULL: begin
                if (!cfg_act)      state_d = ST_IDLE;
                else if (sclk_rise) state_d = ST_OVER;
            end
            ST_OVER:  if (!cfg_act) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        commit   = 1'b0;
        take_bit = 1'b0;
        unique case (state_q)
            ST_SHIFT: take_bit = cfg_act & sclk_rise;
            ST_FULL:  commit   = ~cfg_act;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            shift_q <= '0;
            cnt_q   <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (state_q == ST_IDLE) begin
                cnt_q <= '0;
            end else if (take_bit) begin
                shift_q <= {shift_q[FRAME_BITS-2:0], mosi_s};
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            err_q  <= 1'b0;
        end else if (commit) begin
            addr_q <= shift_q;
            err_q  <= ({1'b0, shift_q} >= LIMIT);
        end
    end

    assign addr_o = addr_q;
    assign err_o  = err_q;

    // R2
    addr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_q) |-> ($past(state_q) == ST_FULL && !$past(cfg_act)));

    // R3
    err_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_q) |-> ($past(state_q) == ST_FULL && !$past(cfg_act)));

    // R7
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> ({1'b0, addr_q} >= LIMIT));
endmodule

// File: rtl/cs_decoder.sv
module cs_decoder #(
    parameter int NUM_OUTS = 16,
    parameter int AW       = 8
) (
    input  logic [AW-1:0]       addr_i,
    output logic [NUM_OUTS-1:0] sel_n_o
);
    for (genvar i = 0; i < NUM_OUTS; i++) begin : g_out
        assign sel_n_o[i] = (addr_i != AW'(i));
    end
endmodule

// File: rtl/spi_select_expander.sv
module spi_select_expander #(
    parameter int NUM_OUTS   = 16,
    parameter int FRAME_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_i,
    input  logic                mosi_i,
    input  logic                cfg_sel_n,
    input  logic                dev_sel_n,
    output logic                sclk_o,
    output logic                mosi_o,
    output logic [NUM_OUTS-1:0] cs_n_o,
    output logic                addr_err_o
);
    localparam logic [FRAME_BITS:0] LIMIT = (FRAME_BITS+1)'(NUM_OUTS);

    logic [3:0]            raw_in, sync_out;
    logic                  sclk_s, mosi_s, cfg_act, dev_act;
    logic [FRAME_BITS-1:0] addr;
    logic                  err;
    logic [NUM_OUTS-1:0]   dec_n;
    logic [NUM_OUTS-1:0]   cs_q;

    assign sclk_o = sclk_i;
    assign mosi_o = mosi_i;

    assign raw_in = {dev_sel_n, cfg_sel_n, mosi_i, sclk_i};

    sync_bank #(.W(4), .RST_VAL(4'b1100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (sync_out)
    );

    assign sclk_s  = sync_out[0];
    assign mosi_s  = sync_out[1];
    assign cfg_act = ~sync_out[2];
    assign dev_act = ~sync_out[3];

    cfg_shifter #(.NUM_OUTS(NUM_OUTS), .FRAME_BITS(FRAME_BITS)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_act (cfg_act),
        .sclk_s  (sclk_s),
        .mosi_s  (mosi_s),
        .addr_o  (addr),
        .err_o   (err)
    );

    cs_decoder #(.NUM_OUTS(NUM_OUTS), .AW(FRAME_BITS)) u_dec (
        .addr_i  (addr),
        .sel_n_o (dec_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cs_q <= '1;
        else if (dev_act && !cfg_act) cs_q <= dec_n;
        else                         cs_q <= '1;
    end

    assign cs_n_o     = cs_q;
    assign addr_err_o = err;

    // R5
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_act |=> (&cs_n_o));

    // R6
    cfg_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_act |=> (&cs_n_o));

    // R4
    cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n_o) <= 1);

    // R7
    cs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cs_n_o) |-> ({1'b0, $past(addr)} < LIMIT));
endmodule

// File: tb/tb_spi_select_expander.sv
`timescale 1ns/1ps
module tb_spi_select_expander;
    localparam int N = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk_i = 1'b0;
    logic         mosi_i = 1'b0;
    logic         cfg_sel_n = 1'b1;
    logic         dev_sel_n = 1'b1;
    logic         sclk_o, mosi_o, addr_err_o;
    logic [N-1:0] cs_n_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] exp_addr = 8'd0;
    logic       exp_err  = 1'b0;

    always #4 clk = ~clk;

    spi_select_expander #(.NUM_OUTS(N), .FRAME_BITS(8)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (sclk_i),
        .mosi_i     (mosi_i),
        .cfg_sel_n  (cfg_sel_n),
        .dev_sel_n  (dev_sel_n),
        .sclk_o     (sclk_o),
        .mosi_o     (mosi_o),
        .cs_n_o     (cs_n_o),
        .addr_err_o (addr_err_o)
    );

    function automatic logic [N-1:0] exp_cs(input logic [7:0] a);
        logic [N-1:0] v = '1;
        if (a < 8'(N)) v[a] = 1'b0;
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_frame(input logic [7:0] data, input int nbits);
        @(negedge clk);
        cfg_sel_n = 1'b0;
        wclk(4);
        for (int i = 0; i < nbits; i++) begin
            mosi_i = data[7 - (i % 8)];
            wclk(4);
            sclk_i = 1'b1;
            wclk(4);
            sclk_i = 1'b0;
        end
        wclk(4);
        cfg_sel_n = 1'b1;
        wclk(6);
        if (nbits == 8) begin
            exp_addr = data;
            exp_err  = (data >= 8'(N));
        end
    endtask

    // device select pulse, checking latency (R9), steering (R4/R7) and release (R5)
    task automatic dev_pulse();
        @(negedge clk);
        dev_sel_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk("R9 before third edge", 32'(cs_n_o), 32'({N{1'b1}}));
        @(posedge clk);
        @(negedge clk);
        chk("R4/R7 steered select", 32'(cs_n_o), 32'(exp_cs(exp_addr)));
        chk("R7 error flag", 32'(addr_err_o), 32'(exp_err));
        wclk(3);
        dev_sel_n = 1'b1;
        wclk(4);
        chk("R5 release after device select", 32'(cs_n_o), 32'({N{1'b1}}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        int nb;
        void'($urandom(32'd1357));

        // reset state with device select low: R5, R8
        dev_sel_n = 1'b0;
        wclk(5);
        chk("R5 outputs high in reset", 32'(cs_n_o), 32'({N{1'b1}}));
        dev_sel_n = 1'b1;
        rst_n = 1'b1;
        wclk(5);
        chk("R8 error clear after reset", 32'(addr_err_o), 32'(0));
        dev_pulse(); // R8: address 0 selected

        // R1 passthrough
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            sclk_i = i[0];
            mosi_i = i[1];
            #1;
            chk("R1 sclk passthrough", 32'(sclk_o), 32'(i[0]));
            chk("R1 mosi passthrough", 32'(mosi_o), 32'(i[1]));
        end
        sclk_i = 1'b0;

        // directed R2: MSB-first, top output
        cfg_frame(8'd11, 8);
        dev_pulse();
        cfg_frame(8'd5, 8);
        dev_pulse();

        // R7: boundary just beyond range, then sticky across short frame, then clear
        cfg_frame(8'd12, 8);
        dev_pulse();
        cfg_frame(8'd3, 7);   // R3 short frame ignored
        dev_pulse();
        cfg_frame(8'd3, 9);   // R3 long frame ignored
        dev_pulse();
        cfg_frame(8'd3, 8);   // R7 clears
        dev_pulse();
        cfg_frame(8'hFF, 8);
        dev_pulse();
        cfg_frame(8'd0, 8);
        dev_pulse();

        // R6: both selects low
        @(negedge clk);
        cfg_sel_n = 1'b0;
        wclk(3);
        dev_sel_n = 1'b0;
        wclk(6);
        chk("R6 config select has priority", 32'(cs_n_o), 32'({N{1'b1}}));
        dev_sel_n = 1'b1;
        wclk(3);
        cfg_sel_n = 1'b1;   // zero-bit frame, R3
        wclk(6);
        dev_pulse();

        // random mix
        for (int k = 0; k < 40; k++) begin
            b = 8'($urandom_range(0, 31));
            if ($urandom_range(0, 3) == 0) b = 8'($urandom);
            case ($urandom_range(0, 5))
                0: nb = 5;
                1: nb = 9;
                default: nb = 8;
            endcase
            cfg_frame(b, nb);
            dev_pulse();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule